// File: doc/BRIEF.md
# Write-Only Tuning Register Receiver on a Two-Wire Serial Bus

This block is the serial front end of a frequency synthesizer. It watches a two-wire bus (a clock line and a bidirectional data line, both sampled by a fast system clock), recognises a START or STOP on the bus, and takes write transfers addressed to it. After the address byte, data arrives in pairs. The top bit of the first byte of each pair tells the receiver which kind of pair it is. A divider pair loads a 15-bit division ratio. A control/band pair loads the charge-pump select, three test bits, two reference-select bits and four band-switch outputs.

The device address is fixed apart from two bits. Those two bits come from a three-level select input, and the all-zero setting of the two bits is always accepted as well. The receiver acknowledges each byte it takes by pulling the data line low for the ninth clock. It never stretches the clock and it never answers a read. A pair only takes effect once both of its bytes have arrived. Because of that, a transfer cut short by STOP or by a repeated START leaves the outputs as they were.

Internally, a sampler synchronises both lines and derives the edges and the bus conditions. An enumerated state machine runs the states `ST_IDLE`, `ST_SHIFT`, `ST_ACK_WAIT`, `ST_ACK` and `ST_SKIP`, and a register bank holds the outputs. The transitions are:
- STOP moves any state to `ST_IDLE`. START moves any state to `ST_SHIFT` and starts address reception.
- When `ST_SHIFT` completes a byte, it moves to `ST_ACK_WAIT` if the byte is accepted and to `ST_SKIP` if it is refused.
- `ST_ACK_WAIT` moves to `ST_ACK` on the next falling clock edge.
- `ST_ACK` moves back to `ST_SHIFT` on the falling edge that ends the ninth clock.
- `ST_SKIP` waits for START or STOP.

Top module: `tuner_i2c_regs`

## Requirements
- R1: After reset the division ratio is 0, cp_sel is 1, test_bits are 000, ref_sel is 00, band_sw is 0000 and sda_pull is 0.
- R2: The address byte is 1,1,0,0,0,A1,A0,W, sent MSB first. The selected (A1,A0) comes from addr_level: 00 (low) gives 00, 01 (middle) gives 10, 10 (high) gives 01, and 11 is treated as low. The receiver acknowledges a write whose (A1,A0) equals the selected pair or 00. Any other address is not acknowledged, and the rest of that transfer is ignored.
- R3: An address byte with W=1 (read) is never acknowledged, and the data that follows it changes no output.
- R4: The receiver pulls SDA low only from the falling SCL edge after the 8th bit of an accepted byte to the falling edge that ends the 9th clock.
- R5: The MSB of the first and of the third data byte selects the type of the pair: 0 means divider, 1 means control/band.
- R6: In a divider pair, bits 6..0 of the first byte become ratio bits 14..8 and the second byte becomes bits 7..0.
- R7: In a control/band pair, bit 6 of the first byte drives cp_sel, bits 5..3 drive test_bits[2:0] and bits 2..1 drive ref_sel[1:0]. Bit 0 is ignored.
- R8: Bits 3..0 of the band byte drive band_sw[3:0]. Bits 7..4 are ignored.
- R9: A pair updates its outputs only once its second byte is complete. A first byte left alone by a STOP or a repeated START changes nothing.
- R10: Data bytes after the fourth in one transfer are not acknowledged and change nothing.
- R11: START restarts address reception from any state, and STOP ends any transfer and releases SDA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous reset, active low |
| scl | input | 1 | Bus clock line level |
| sda | input | 1 | Bus data line level |
| addr_level | input | 2 | Decoded three-level address select (00 low, 01 middle, 10 high) |
| sda_pull | output | 1 | 1 pulls SDA low (acknowledge) |
| div_ratio | output | 15 | Division ratio |
| cp_sel | output | 1 | Charge-pump current select |
| test_bits | output | 3 | Test mode bits |
| ref_sel | output | 2 | Reference divider select |
| band_sw | output | 4 | Band switch outputs |

## Verification
The assertions check these points on every cycle:
- The acknowledge pull starts and ends only while the synchronised clock is low.
- STOP always releases the data line.
- Every output register holds its value unless a pair is completing.
- The data-byte index never passes its limit.

Whether the right bytes are acknowledged can only be shown by the bench's scenarios, which drive whole transfers and compare against a reference model. The same holds for field placement, the three address levels, all four pair orders and the discarding of half-finished pairs.

// File: rtl/tnr_pkg.sv
package tnr_pkg;

    localparam int BYTE_W = 8;
    localparam int TEST_W = 3;
    localparam int REF_W  = 2;
    localparam int BAND_W = 4;

    localparam logic [4:0] ADDR_FIXED = 5'b11000;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_ACK_WAIT,
        ST_ACK,
        ST_SKIP
    } rx_state_t;

    // addr_level: 00 low, 01 middle, 10 high, 11 as low; result is {A1,A0}
    function automatic logic [1:0] level_to_sel(input logic [1:0] lvl);
        logic [1:0] sel;
        case (lvl)
            2'b01:   sel = 2'b10;
            2'b10:   sel = 2'b01;
            default: sel = 2'b00;
        endcase
        return sel;
    endfunction

endpackage

// File: rtl/tnr_bus_sync.sv
module tnr_bus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_q,
    output logic sda_q,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [STAGES-1:0] scl_ff;
    logic [STAGES-1:0] sda_ff;
    logic              scl_p;
    logic              sda_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_ff <= '1;
            sda_ff <= '1;
            scl_p  <= 1'b1;
            sda_p  <= 1'b1;
        end else begin
            scl_ff[0] <= scl_i;
            sda_ff[0] <= sda_i;
            for (int i = 1; i < STAGES; i++) begin
                scl_ff[i] <= scl_ff[i-1];
                sda_ff[i] <= sda_ff[i-1];
            end
            scl_p <= scl_ff[STAGES-1];
            sda_p <= sda_ff[STAGES-1];
        end
    end

    assign scl_q     = scl_ff[STAGES-1];
    assign sda_q     = sda_ff[STAGES-1];
    assign scl_rise  = scl_q & ~scl_p;
    assign scl_fall  = ~scl_q & scl_p;
    assign start_det = scl_q & scl_p & sda_p & ~sda_q;
    assign stop_det  = scl_q & scl_p & ~sda_p & sda_q;

endmodule

// File: rtl/tnr_rx_fsm.sv
module tnr_rx_fsm
    import tnr_pkg::*;
#(
    parameter int MAX_DATA = 4,
    parameter int IDX_W    = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                scl_rise,
    input  logic                scl_fall,
    input  logic                start_det,
    input  logic                stop_det,
    input  logic                sda_q,
    input  logic [1:0]          ca_sel,
    output logic                sda_pull,
    output logic                byte_stb,
    output logic [BYTE_W-1:0]   byte_val,
    output logic [IDX_W-1:0]    data_idx
);

    localparam logic [IDX_W-1:0] IDX_LIMIT = IDX_W'(MAX_DATA);

    rx_state_t          state;
    rx_state_t          nxt;
    logic [BYTE_W-1:0]  shreg;
    logic [2:0]         bit_cnt;
    logic               addr_phase;
    logic [BYTE_W-1:0]  full;
    logic               byte_done;
    logic               addr_hit;
    logic               take_byte;

    assign full      = {shreg[BYTE_W-2:0], sda_q};
    assign byte_done = scl_rise && (bit_cnt == 3'd7);
    assign addr_hit  = (full[7:3] == ADDR_FIXED) && !full[0]
                       && ((full[2:1] == 2'b00) || (full[2:1] == ca_sel));
    assign take_byte = addr_phase ? addr_hit : (data_idx < IDX_LIMIT);

    // next-state logic
    always_comb begin
        nxt = state;
        if (stop_det) begin
            nxt = ST_IDLE;
        end else if (start_det) begin
            nxt = ST_SHIFT;
        end else begin
            unique case (state)
                ST_IDLE:     nxt = ST_IDLE;
                ST_SHIFT:    if (byte_done) nxt = take_byte ? ST_ACK_WAIT : ST_SKIP;
                ST_ACK_WAIT: if (scl_fall) nxt = ST_ACK;
                ST_ACK:      if (scl_fall) nxt = ST_SHIFT;
                ST_SKIP:     nxt = ST_SKIP;
                default:     nxt = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // byte datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg      <= '0;
            bit_cnt    <= '0;
            addr_phase <= 1'b1;
            data_idx   <= '0;
            byte_stb   <= 1'b0;
            byte_val   <= '0;
        end else begin
            byte_stb <= 1'b0;
            if (stop_det || start_det) begin
                bit_cnt    <= '0;
                addr_phase <= 1'b1;
                data_idx   <= '0;
            end else begin
                if (state == ST_SHIFT && scl_rise) begin
                    shreg   <= full;
                    bit_cnt <= bit_cnt + 3'd1;
                    if (byte_done && !addr_phase && take_byte) begin
                        byte_stb <= 1'b1;
                        byte_val <= full;
                    end
                end
                if (state == ST_ACK && scl_fall) begin
                    addr_phase <= 1'b0;
                    bit_cnt    <= '0;
                end
                if (byte_stb) data_idx <= data_idx + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        sda_pull = (state == ST_ACK);
    end

endmodule

// File: rtl/tnr_reg_bank.sv
module tnr_reg_bank
    import tnr_pkg::*;
#(
    parameter int         DIV_W       = 15,
    parameter logic       CP_DEFAULT  = 1'b1,
    parameter logic [1:0] REF_DEFAULT = 2'b00
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                first_stb,
    input  logic                pair_commit,
    input  logic [BYTE_W-1:0]   byte_val,
    output logic [DIV_W-1:0]    div_ratio,
    output logic                cp_sel,
    output logic [TEST_W-1:0]   test_bits,
    output logic [REF_W-1:0]    ref_sel,
    output logic [BAND_W-1:0]   band_sw
);

    localparam int HI_W = DIV_W - BYTE_W;

    logic [BYTE_W-1:0] first_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            first_q   <= '0;
            div_ratio <= '0;
            cp_sel    <= CP_DEFAULT;
            test_bits <= '0;
            ref_sel   <= REF_DEFAULT;
            band_sw   <= '0;
        end else begin
            if (first_stb) first_q <= byte_val;
            if (pair_commit) begin
                if (!first_q[7]) begin
                    div_ratio <= {first_q[HI_W-1:0], byte_val};
                end else begin
                    cp_sel    <= first_q[6];
                    test_bits <= first_q[5:3];
                    ref_sel   <= first_q[2:1];
                    band_sw   <= byte_val[BAND_W-1:0];
                end
            end
        end
    end

endmodule

// File: rtl/tuner_i2c_regs.sv
module tuner_i2c_regs
    import tnr_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int MAX_DATA    = 4,
    parameter int DIV_W       = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl,
    input  logic              sda,
    input  logic [1:0]        addr_level,
    output logic              sda_pull,
    output logic [DIV_W-1:0]  div_ratio,
    output logic              cp_sel,
    output logic [2:0]        test_bits,
    output logic [1:0]        ref_sel,
    output logic [3:0]        band_sw
);

    localparam int IDX_W = $clog2(MAX_DATA + 1);

    logic              scl_q;
    logic              sda_q;
    logic              scl_rise;
    logic              scl_fall;
    logic              start_det;
    logic              stop_det;
    logic              byte_stb;
    logic [BYTE_W-1:0] byte_val;
    logic [IDX_W-1:0]  data_idx;
    logic              first_stb;
    logic              pair_commit;
    logic [1:0]        ca_sel;

    assign ca_sel      = level_to_sel(addr_level);
    assign first_stb   = byte_stb & ~data_idx[0];
    assign pair_commit = byte_stb &  data_idx[0];

    tnr_bus_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl),
        .sda_i     (sda),
        .scl_q     (scl_q),
        .sda_q     (sda_q),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    tnr_rx_fsm #(.MAX_DATA(MAX_DATA), .IDX_W(IDX_W)) fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .sda_q     (sda_q),
        .ca_sel    (ca_sel),
        .sda_pull  (sda_pull),
        .byte_stb  (byte_stb),
        .byte_val  (byte_val),
        .data_idx  (data_idx)
    );

    tnr_reg_bank #(.DIV_W(DIV_W)) bank_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .first_stb   (first_stb),
        .pair_commit (pair_commit),
        .byte_val    (byte_val),
        .div_ratio   (div_ratio),
        .cp_sel      (cp_sel),
        .test_bits   (test_bits),
        .ref_sel     (ref_sel),
        .band_sw     (band_sw)
    );

endmodule

// File: rtl/tnr_sva_chk.sv
module tnr_sva_chk #(
    parameter int DIV_W    = 15,
    parameter int IDX_W    = 3,
    parameter int MAX_DATA = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             scl_q,
    input logic             sda_pull,
    input logic             stop_det,
    input logic             pair_commit,
    input logic [IDX_W-1:0] data_idx,
    input logic [DIV_W-1:0] div_ratio,
    input logic             cp_sel,
    input logic [2:0]       test_bits,
    input logic [1:0]       ref_sel,
    input logic [3:0]       band_sw
);

    AST_PULL_STARTS_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull) |-> !scl_q); // R4

    AST_PULL_ENDS_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_pull) |-> !scl_q); // R4

    AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_pull); // R11

    AST_DIV_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !pair_commit |=> $stable(div_ratio)); // R9

    AST_CTRL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !pair_commit |=> $stable({cp_sel, test_bits, ref_sel})); // R7

    AST_BAND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !pair_commit |=> $stable(band_sw)); // R8

    AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        int'(data_idx) <= MAX_DATA); // R10

endmodule

bind tuner_i2c_regs tnr_sva_chk #(
    .DIV_W    (DIV_W),
    .IDX_W    (IDX_W),
    .MAX_DATA (MAX_DATA)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_q       (scl_q),
    .sda_pull    (sda_pull),
    .stop_det    (stop_det),
    .pair_commit (pair_commit),
    .data_idx    (data_idx),
    .div_ratio   (div_ratio),
    .cp_sel      (cp_sel),
    .test_bits   (test_bits),
    .ref_sel     (ref_sel),
    .band_sw     (band_sw)
);

// File: tb/tuner_i2c_regs_tb_top.sv
module tuner_i2c_regs_tb_top;

    localparam int Q = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic [1:0]  addr_level = 2'b00;
    logic        sda_pull;
    logic [14:0] div_ratio;
    logic        cp_sel;
    logic [2:0]  test_bits;
    logic [1:0]  ref_sel;
    logic [3:0]  band_sw;
    logic        sda_line;

    assign sda_line = sda_m & ~sda_pull;

    always #5 clk = ~clk;

    tuner_i2c_regs dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl        (scl_m),
        .sda        (sda_line),
        .addr_level (addr_level),
        .sda_pull   (sda_pull),
        .div_ratio  (div_ratio),
        .cp_sel     (cp_sel),
        .test_bits  (test_bits),
        .ref_sel    (ref_sel),
        .band_sw    (band_sw)
    );

    int checks = 0;
    int errors = 0;
    int blank  = 0;
    bit run_cmp = 0;
    bit done = 0;

    // reference model state
    logic [14:0] exp_div = '0;
    logic        exp_cp = 1'b1;
    logic [2:0]  exp_test = '0;
    logic [1:0]  exp_ref = '0;
    logic [3:0]  exp_band = '0;
    logic [14:0] pnd_div;
    logic        pnd_cp;
    logic [2:0]  pnd_test;
    logic [1:0]  pnd_ref;
    logic [3:0]  pnd_band;
    logic [7:0]  txq[$];

    task automatic chk(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s got %h exp %h at %0t", tag, what, got, exp, $time);
        end
    endtask

    task automatic check_all(input string tag);
        chk(tag, "div_ratio", 32'(div_ratio), 32'(exp_div));
        chk(tag, "cp_sel", 32'(cp_sel), 32'(exp_cp));
        chk(tag, "test_bits", 32'(test_bits), 32'(exp_test));
        chk(tag, "ref_sel", 32'(ref_sel), 32'(exp_ref));
        chk(tag, "band_sw", 32'(band_sw), 32'(exp_band));
    endtask

    // per-clock comparison against the model, outside the settle window after an SCL rise
    always @(negedge clk) begin
        if (blank > 0) blank--;
        else if (run_cmp) begin
            chk("R6", "div_ratio", 32'(div_ratio), 32'(exp_div));
            chk("R7", "ctrl", 32'({cp_sel, test_bits, ref_sel}), 32'({exp_cp, exp_test, exp_ref}));
            chk("R8", "band_sw", 32'(band_sw), 32'(exp_band));
        end
    end

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic bit addr_ok(input logic [7:0] b, input logic [1:0] lvl);
        logic [1:0] sel;
        sel = (lvl == 2'b01) ? 2'b10 : (lvl == 2'b10) ? 2'b01 : 2'b00;
        return (b[7:3] == 5'b11000) && !b[0] && (b[2:1] == 2'b00 || b[2:1] == sel);
    endfunction

    task automatic bus_start();
        sda_m = 1'b1; wq(Q);
        scl_m = 1'b1; wq(Q);
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b1; wq(Q);
        sda_m = 1'b1; wq(2 * Q);
    endtask

    task automatic send_byte(input logic [7:0] b, input bit apply);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wq(Q);
            if (i == 0 && apply) begin
                exp_div = pnd_div; exp_cp = pnd_cp; exp_test = pnd_test;
                exp_ref = pnd_ref; exp_band = pnd_band;
            end
            blank = 8;
            scl_m = 1'b1; wq(2 * Q);
            scl_m = 1'b0; wq(Q);
        end
    endtask

    task automatic recv_ack(input bit exp_ack, input string tag);
        sda_m = 1'b1; wq(Q);
        scl_m = 1'b1; wq(Q);
        chk(tag, "ack line", 32'(sda_line), 32'(!exp_ack));
        wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic run_txn(input bit end_stop, input string atag);
        bit addressed = 0;
        int di = 0;
        logic [7:0] first = '0;
        bus_start();
        foreach (txq[k]) begin
            bit acc;
            bit apply = 0;
            string tag = "R4";
            if (k == 0) begin
                acc = addr_ok(txq[0], addr_level);
                addressed = acc;
                tag = atag;
            end else if (!addressed) begin
                acc = 0; tag = atag;
            end else if (di >= 4) begin
                acc = 0; tag = "R10";
            end else begin
                acc = 1;
                if (di % 2 == 0) first = txq[k];
                else begin
                    apply = 1;
                    pnd_div = exp_div; pnd_cp = exp_cp; pnd_test = exp_test;
                    pnd_ref = exp_ref; pnd_band = exp_band;
                    if (!first[7]) pnd_div = {first[6:0], txq[k]};
                    else begin
                        pnd_cp = first[6]; pnd_test = first[5:3];
                        pnd_ref = first[2:1]; pnd_band = txq[k][3:0];
                    end
                end
                di++;
            end
            send_byte(txq[k], apply);
            recv_ack(acc, tag);
        end
        if (end_stop) bus_stop();
    endtask

    initial begin
        wq(5);
        rst_n = 1'b1;
        wq(2);
        // R1: reset values
        check_all("R1");
        chk("R1", "sda_pull", 32'(sda_pull), 32'd0);
        run_cmp = 1;

        // R5 R6: divider pair
        txq = '{8'hC0, 8'h12, 8'h34}; run_txn(1, "R2");
        check_all("R6");
        // R7 R8: control/band pair, upper band nibble ignored
        txq = '{8'hC0, 8'hA6, 8'hF5}; run_txn(1, "R2");
        check_all("R7");
        // R5: control/band then divider
        txq = '{8'hC0, 8'hC0, 8'h0A, 8'h7F, 8'hFF}; run_txn(1, "R2");
        check_all("R5");
        // R5: divider then control/band
        txq = '{8'hC0, 8'h01, 8'h00, 8'h9A, 8'h03}; run_txn(1, "R2");
        check_all("R5");
        // R2: address not selected at low level
        txq = '{8'hC4, 8'h05, 8'h55}; run_txn(1, "R2");
        check_all("R2");
        // R3: read request refused, data ignored
        txq = '{8'hC1, 8'h05, 8'h55}; run_txn(1, "R3");
        check_all("R3");
        // R9: lone first byte cut by STOP
        txq = '{8'hC0, 8'h22}; run_txn(1, "R2");
        check_all("R9");
        // R9 R11: lone first byte cut by repeated START, then a full pair
        txq = '{8'hC0, 8'h33}; run_txn(0, "R2");
        txq = '{8'hC0, 8'h44, 8'h01}; run_txn(1, "R11");
        check_all("R11");
        // R10: bytes beyond the fourth
        txq = '{8'hC0, 8'h05, 8'h06, 8'h80, 8'h01, 8'h07, 8'h08}; run_txn(1, "R2");
        check_all("R10");
        // R2: middle level
        addr_level = 2'b01;
        txq = '{8'hC4, 8'h11, 8'h22}; run_txn(1, "R2");
        txq = '{8'hC0, 8'hE4, 8'h09}; run_txn(1, "R2");
        txq = '{8'hC2, 8'h66, 8'h77}; run_txn(1, "R2");
        check_all("R2");
        // R2: high level
        addr_level = 2'b10;
        txq = '{8'hC2, 8'h2A, 8'hBC}; run_txn(1, "R2");
        txq = '{8'hC4, 8'h01, 8'h02}; run_txn(1, "R2");
        check_all("R2");
        // R2: unused code acts as low
        addr_level = 2'b11;
        txq = '{8'hC0, 8'h3C, 8'hDE}; run_txn(1, "R2");
        txq = '{8'hC2, 8'h01, 8'h02}; run_txn(1, "R2");
        check_all("R2");
        wq(20);
        chk("R11", "sda_pull idle", 32'(sda_pull), 32'd0);

        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired got %0d exp 0", 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule